// File: doc/BRIEF.md
# Locked-Rotor Protection Timer

This block watches a single tachometer signal derived from one Hall sensor and decides whether the motor is turning. A saturating up/down accumulator stands in for a timing capacitor. It climbs by a fixed step on every timebase tick. Every rising or falling tach edge knocks it back by a fixed amount. If the tach edges stop coming, or come too slowly, the accumulator reaches its upper threshold and the motor is declared stalled.

While stalled, the block runs a retry cycle on its own. The drive is held off while the accumulator bleeds down slowly to the lower threshold. Drive is then allowed again while the accumulator climbs back to the upper threshold at the fast rate. With a fall step that is one fourteenth of the rise step, the off interval lasts fourteen times as long as the on interval.

A tach edge seen during an on interval means the rotor has moved. That edge cancels the retry cycle and normal monitoring resumes. Clearing the enable input disables protection entirely. The thresholds, steps and per-edge drop are parameters, so the trip frequency can be scaled to whatever tick rate is supplied.

Top module: `lockrot_timer`

## Requirements
- R1: After synchronous reset, `drive_en` is 1, `locked` is 0 and the accumulator is 0.
- R2: While running, each `tick` adds RISE_STEP and each tach transition (either polarity) subtracts EDGE_DROP, floored at 0. When the result reaches HI_TH, `locked` goes to 1 and `drive_en` goes to 0 at the same clock edge. With a tach edge every P ticks, a stall is declared exactly when RISE_STEP*P > EDGE_DROP (or when RISE_STEP*P >= HI_TH).
- R3: In the off interval, each `tick` subtracts FALL_STEP. When the accumulator reaches LO_TH, `drive_en` returns to 1 while `locked` stays 1. The off interval lasts (HI_TH-LO_TH)/FALL_STEP ticks.
- R4: In the on interval, each `tick` adds RISE_STEP. When the accumulator reaches HI_TH, `drive_en` returns to 0. The on interval lasts (HI_TH-LO_TH)/RISE_STEP ticks, which is one fourteenth of the off interval for the default steps.
- R5: Tach edges during the off interval are ignored: they neither shorten the off interval nor change the outputs.
- R6: A tach edge during the on interval releases the protection: `locked` goes to 0, `drive_en` stays 1, and normal running monitoring resumes.
- R7: While `enable` is 0, the accumulator is held at 0, `locked` is 0 and `drive_en` is 1 at the next clock edge, whatever ticks arrive.
- R8: The accumulator never exceeds HI_TH.
- R9: `tach` passes through a two-flop synchronizer. A tach change shows at the outputs at the third rising clock edge after it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | 1 = protection active, 0 = protection disabled and cleared |
| tick | input | 1 | One-cycle timebase strobe that steps the accumulator |
| tach | input | 1 | Asynchronous Hall-derived tachometer level |
| drive_en | output | 1 | Registered: 1 = drive allowed |
| locked | output | 1 | Registered: 1 = rotor considered stalled |

## Verification
The main function is tried with regular tach edge trains whose period sweeps from one to nine ticks. This separates periods whose net charge per period is zero or negative (no trip, including the exact balance point) from those that creep up and from those that hit the threshold before the first edge. An edge-free run from a cleared state measures the trip time and the lengths of the off and on intervals in ticks, and so exposes any error in the step sizes or the threshold comparisons. Edges injected during an off interval must leave its length unchanged. An edge during an on interval must release the lock at exactly the third clock edge, which tells the release path apart from the synchronizer latency. Dropping the enable in mid-cycle checks the bypass.

// File: rtl/lockrot_pkg.sv
package lockrot_pkg;
  typedef enum logic [1:0] {
    LR_RUN = 2'd0,
    LR_OFF = 2'd1,
    LR_ON  = 2'd2
  } lr_state_e;
endpackage

// File: rtl/lockrot_edge_sync.sv
module lockrot_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic toggle
);
  logic [SYNC_STAGES:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q[0] <= 1'b0;
    else     pipe_q[0] <= din;
  end

  for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe_q[i] <= 1'b0;
      else     pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign toggle = pipe_q[SYNC_STAGES] ^ pipe_q[SYNC_STAGES-1];
endmodule

// File: rtl/lockrot_accum.sv
module lockrot_accum #(
  parameter int ACC_W     = 12,
  parameter int RISE_STEP = 14,
  parameter int FALL_STEP = 1,
  parameter int EDGE_DROP = 56,
  parameter int HI_TH     = 2800,
  parameter int LO_TH     = 700
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             rise,
  input  logic             fall,
  input  logic             kick,
  output logic [ACC_W-1:0] acc_q,
  output logic             nxt_hi,
  output logic             nxt_lo
);
  localparam int XW = ACC_W + 1;
  localparam logic [XW-1:0] RISE_X = XW'(RISE_STEP);
  localparam logic [XW-1:0] FALL_X = XW'(FALL_STEP);
  localparam logic [XW-1:0] DROP_X = XW'(EDGE_DROP);
  localparam logic [XW-1:0] HI_X   = XW'(HI_TH);
  localparam logic [XW-1:0] LO_X   = XW'(LO_TH);

  logic [XW-1:0] up_v, down_v, nxt_v;

  always_comb begin
    up_v   = {1'b0, acc_q} + (rise ? RISE_X : '0);
    down_v = (fall ? FALL_X : '0) + (kick ? DROP_X : '0);
    nxt_v  = (down_v >= up_v) ? '0 : (up_v - down_v);
    nxt_hi = (nxt_v >= HI_X);
    nxt_lo = (nxt_v <= LO_X);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) acc_q <= '0;
    else if (nxt_hi)  acc_q <= HI_X[ACC_W-1:0];
    else              acc_q <= nxt_v[ACC_W-1:0];
  end
endmodule

// File: rtl/lockrot_ctrl.sv
module lockrot_ctrl
  import lockrot_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic tick,
  input  logic tach_edge,
  input  logic nxt_hi,
  input  logic nxt_lo,
  output logic clear,
  output logic rise,
  output logic fall,
  output logic kick,
  output logic drive_en,
  output logic locked
);
  lr_state_e st_q, st_d;

  always_comb begin
    clear = ~enable;
    rise  = 1'b0;
    fall  = 1'b0;
    kick  = 1'b0;
    st_d  = st_q;
    case (st_q)
      LR_RUN: begin
        rise = tick;
        kick = tach_edge;
        if (nxt_hi) st_d = LR_OFF;
      end
      LR_OFF: begin
        fall = tick;
        if (nxt_lo) st_d = LR_ON;
      end
      LR_ON: begin
        rise = tick;
        kick = tach_edge;
        if (tach_edge)   st_d = LR_RUN;
        else if (nxt_hi) st_d = LR_OFF;
      end
      default: st_d = LR_RUN;
    endcase
    if (!enable) st_d = LR_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= LR_RUN;
      drive_en <= 1'b1;
      locked   <= 1'b0;
    end else begin
      st_q     <= st_d;
      drive_en <= (st_d != LR_OFF);
      locked   <= (st_d != LR_RUN);
    end
  end
endmodule

// File: rtl/lockrot_timer.sv
module lockrot_timer #(
  parameter int ACC_W       = 12,
  parameter int RISE_STEP   = 14,
  parameter int FALL_STEP   = 1,
  parameter int EDGE_DROP   = 56,
  parameter int HI_TH       = 2800,
  parameter int LO_TH       = 700,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic tick,
  input  logic tach,
  output logic drive_en,
  output logic locked
);
  logic             tach_edge;
  logic             clear, rise, fall, kick;
  logic             nxt_hi, nxt_lo;
  logic [ACC_W-1:0] acc_q;

  lockrot_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(tach), .toggle(tach_edge)
  );

  lockrot_accum #(
    .ACC_W(ACC_W), .RISE_STEP(RISE_STEP), .FALL_STEP(FALL_STEP),
    .EDGE_DROP(EDGE_DROP), .HI_TH(HI_TH), .LO_TH(LO_TH)
  ) u_acc (
    .clk(clk), .rst(rst), .clear(clear), .rise(rise), .fall(fall),
    .kick(kick), .acc_q(acc_q), .nxt_hi(nxt_hi), .nxt_lo(nxt_lo)
  );

  lockrot_ctrl u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .tick(tick),
    .tach_edge(tach_edge), .nxt_hi(nxt_hi), .nxt_lo(nxt_lo),
    .clear(clear), .rise(rise), .fall(fall), .kick(kick),
    .drive_en(drive_en), .locked(locked)
  );
endmodule

// File: rtl/lockrot_timer_chk.sv
module lockrot_timer_chk #(
  parameter int ACC_W = 12,
  parameter int HI_TH = 2800,
  parameter int LO_TH = 700
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             drive_en,
  input logic             locked,
  input logic [ACC_W-1:0] acc
);
  AST_OFF_IMPLIES_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !drive_en |-> locked); // R3
  AST_ACC_CEILING: assert property (@(posedge clk) disable iff (rst)
    acc <= ACC_W'(HI_TH)); // R8
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!locked && drive_en && acc == '0)); // R7
  AST_OFF_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    (!drive_en && $past(!drive_en)) |-> acc <= $past(acc)); // R5
  AST_TRIP_STARTS_OFF: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> !drive_en); // R2
  AST_RELEASE_DRIVES: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> drive_en); // R6
  AST_ON_FROM_LOW: assert property (@(posedge clk) disable iff (rst)
    ($rose(drive_en) && locked) |-> acc <= ACC_W'(LO_TH)); // R3
endmodule

bind lockrot_timer lockrot_timer_chk #(
  .ACC_W(ACC_W), .HI_TH(HI_TH), .LO_TH(LO_TH)
) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .drive_en(drive_en),
  .locked(locked), .acc(acc_q)
);

// File: tb/lockrot_timer_tb.sv
module lockrot_timer_tb;
  localparam int RISE = 14;
  localparam int FALL = 1;
  localparam int DROP = 56;
  localparam int HI   = 112;
  localparam int LO   = 28;
  localparam int OFF_TICKS = (HI - LO) / FALL;
  localparam int ON_TICKS  = (HI - LO) / RISE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic tick = 1'b0;
  logic tach = 1'b0;
  logic drive_en, locked;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  lockrot_timer #(
    .ACC_W(8), .RISE_STEP(RISE), .FALL_STEP(FALL), .EDGE_DROP(DROP),
    .HI_TH(HI), .LO_TH(LO), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .tick(tick), .tach(tach),
    .drive_en(drive_en), .locked(locked)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic flip_tach();
    tach = ~tach;
    repeat (4) @(negedge clk);
  endtask

  task automatic restart();
    enable = 1'b0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int cnt;
    int on_len;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(drive_en == 1'b1, "R1 drive_en", drive_en, 1);
    check(locked == 1'b0, "R1 locked", locked, 0);

    // R7 disabled: ticks never trip
    for (int k = 0; k < 20; k++) pulse_tick();
    check(locked == 1'b0, "R7 locked while disabled", locked, 0);
    check(drive_en == 1'b1, "R7 drive while disabled", drive_en, 1);

    // R2 trip from cleared state: HI/RISE ticks
    restart();
    cnt = 0;
    while (!locked && cnt < 50) begin pulse_tick(); cnt++; end
    check(cnt == HI / RISE, "R2 ticks to trip", cnt, HI / RISE);
    check(drive_en == 1'b0, "R2 drive off at trip", drive_en, 0);

    // R3 off interval length
    cnt = 0;
    while (!drive_en && cnt < 200) begin pulse_tick(); cnt++; end
    check(cnt == OFF_TICKS, "R3 off ticks", cnt, OFF_TICKS);
    check(locked == 1'b1, "R3 locked in on interval", locked, 1);

    // R4 on interval length and ratio
    cnt = 0;
    while (drive_en && cnt < 50) begin pulse_tick(); cnt++; end
    on_len = cnt;
    check(on_len == ON_TICKS, "R4 on ticks", on_len, ON_TICKS);
    check(OFF_TICKS == 14 * on_len, "R4 off/on ratio", OFF_TICKS, 14 * on_len);

    // R5 edge in off interval ignored
    for (int k = 0; k < 10; k++) pulse_tick();
    flip_tach();
    check(locked == 1'b1 && drive_en == 1'b0, "R5 outputs after off edge", {locked, drive_en}, 2);
    cnt = 10;
    while (!drive_en && cnt < 200) begin pulse_tick(); cnt++; end
    check(cnt == OFF_TICKS, "R5 off length with edge", cnt, OFF_TICKS);

    // R9 / R6 release timing during on interval
    tach = ~tach;
    repeat (2) @(negedge clk);
    check(locked == 1'b1, "R9 no change after two edges", locked, 1);
    @(negedge clk);
    check(locked == 1'b0, "R6 released at third edge", locked, 0);
    check(drive_en == 1'b1, "R6 drive after release", drive_en, 1);
    @(negedge clk);

    // R6 normal running resumes: edge every 3 ticks holds
    for (int k = 0; k < 30; k++) begin
      pulse_tick();
      if ((k + 1) % 3 == 0) flip_tach();
    end
    check(locked == 1'b0, "R6 running after release", locked, 0);

    // R2 period sweep
    for (int p = 1; p <= 9; p++) begin
      bit exp_lock;
      restart();
      for (int k = 0; k < 45; k++) begin
        pulse_tick();
        if ((k + 1) % p == 0) flip_tach();
      end
      exp_lock = (RISE * p > DROP) || (RISE * p >= HI);
      check(locked == exp_lock, $sformatf("R2 sweep period %0d", p), locked, exp_lock);
    end

    // R8 saturation: extra ticks after a clean trip keep the same off length
    restart();
    for (int k = 0; k < 8; k++) pulse_tick();
    cnt = 0;
    while (!drive_en && cnt < 200) begin pulse_tick(); cnt++; end
    check(cnt == OFF_TICKS, "R8 off length from ceiling", cnt, OFF_TICKS);

    // R7 disable during off interval
    restart();
    for (int k = 0; k < 8; k++) pulse_tick();
    check(locked == 1'b1, "R7 precondition trip", locked, 1);
    enable = 1'b0;
    @(negedge clk);
    check(locked == 1'b0 && drive_en == 1'b1, "R7 disable clears", {locked, drive_en}, 1);
    enable = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 7; k++) pulse_tick();
    check(locked == 1'b0, "R7 accumulator cleared", locked, 0);

    finish_run();
  end
endmodule